// File: doc/BRIEF.md
# Chip-Select Address Window Decoder

This block compares a system address against eight programmable address windows and names the one window that claims it. Each window is described by a configuration word written over a simple write port. The word holds a 6-bit base in 16 MB units, a 4-bit size code and a valid bit. The decoder drives a one-hot select vector, or a miss flag when no valid window matches. A per-window flag marks size codes that are outside the legal set.

Each window also carries a 2-bit device-type field. A second configuration word describes a FIFO engine through an enable bit and a chip-select field. When the selected window holds a NAND-type device and the enabled engine is assigned to that window, the access is steered to the FIFO-engine port. In every other case it goes to the direct device port. All outputs are combinational from the address and the registered configuration, so a decoder in front of a memory bus can use them in the same cycle as the address.

Top module: `cs_window_decoder`

## Requirements
- R1: Reset state. After reset, every window has size code 0xF, base 0 and device type 0, and the engine is disabled. Only window 0 is valid, so addresses 0x00000000 to 0x00FFFFFF select window 0 and every other address misses.
- R2: A write with `win_we` high loads the window named by `win_idx` from `win_wdata`, using these fields: base = bits [5:0], valid = bit 6, size code = bits [11:8]. Bit 7 and bits [31:12] have no effect on any output.
- R3: A window matches under two conditions. Address bits [31:28] must equal {2'b00, base[5:4]}. Address bits [27:24] must also equal base[3:0] in every bit position where the size code holds a 1. So code 0xF gives 16 MB, 0xC gives 64 MB, 0x8 gives 128 MB and 0x0 gives 256 MB.
- R4: A window whose valid bit is 0 never matches.
- R5: When several valid windows match, only the lowest-numbered one is asserted in `win_sel`. `win_sel` is never more than one-hot.
- R6: `win_miss` is 1 exactly when `win_sel` is all zero.
- R7: A configuration write takes effect on the outputs right after the clock edge that captures it. Before that edge the old configuration still decides. An address change affects the outputs in the same cycle.
- R8: `mask_bad[i]` is 1 when window i is valid and its size code is not one of 0x8, 0xC, 0xE or 0xF. Code 0x0 counts as legal while `accept_256` is 1. A flagged window still decodes per R3.
- R9: `to_fifo` is 1 exactly when three conditions hold: a window i is selected, that window's device type equals 2 (NAND), and the engine is enabled with its chip-select field equal to i.
- R10: A write with `type_we` high loads `type_wdata` as the device type of window `win_idx`. A write with `eng_we` high loads the engine enable from bit 7 and the engine chip-select from bits [26:24] of `eng_wdata`. The other bits of `eng_wdata` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| accept_256 | input | 1 | Treat size code 0x0 (256 MB) as legal |
| win_we | input | 1 | Window configuration write strobe |
| win_idx | input | 3 | Window index for configuration and type writes |
| win_wdata | input | 32 | Window configuration word |
| type_we | input | 1 | Device-type write strobe |
| type_wdata | input | 2 | Device type (2 = NAND) |
| eng_we | input | 1 | FIFO-engine configuration write strobe |
| eng_wdata | input | 32 | Engine word: enable bit 7, chip-select bits [26:24] |
| addr | input | 32 | System address to decode |
| win_sel | output | 8 | One-hot selected window |
| win_miss | output | 1 | No valid window matches |
| to_fifo | output | 1 | Selected access is steered to the FIFO-engine port |
| mask_bad | output | 8 | Per-window illegal size-code flag |

## Verification
The select, miss, routing and flag outputs follow a new address with no delay. The bench therefore drives each address on a falling edge and compares one time unit later, well before the next rising edge. A configuration write is due one rising edge after its strobe. One check samples the old decode while the strobe is still pending, then samples again after the edge. Reset leaves the synchronizer two edges behind the pin, and the sweeps begin only after that delay has passed.

// File: rtl/cswd_pkg.sv
package cswd_pkg;
  localparam int BASE_W     = 6;
  localparam int MASK_W     = 4;
  localparam int DTYPE_W    = 2;
  localparam int ECS_W      = 3;
  localparam int UNIT_LSB   = 24;
  localparam int VALID_BIT  = 6;
  localparam int MASK_LSB   = 8;
  localparam int ENG_EN_BIT = 7;
  localparam int ENG_CS_LSB = 24;
  localparam logic [DTYPE_W-1:0] DT_NAND  = 2'd2;
  localparam logic [MASK_W-1:0]  MASK_RST = 4'hF;

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic              valid;
    logic [BASE_W-1:0] base;
  } win_cfg_t;

  function automatic logic mask_is_legal(input logic [MASK_W-1:0] m, input logic acc);
    return (m == 4'h8) || (m == 4'hC) || (m == 4'hE) || (m == 4'hF) ||
           ((m == 4'h0) && acc);
  endfunction
endpackage

// File: rtl/cswd_rst_sync.sv
module cswd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cswd_cfg_regs.sv
module cswd_cfg_regs
  import cswd_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int IDX_W   = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             win_we,
  input  logic [IDX_W-1:0]                 win_idx,
  input  logic [31:0]                      win_wdata,
  input  logic                             type_we,
  input  logic [DTYPE_W-1:0]               type_wdata,
  input  logic                             eng_we,
  input  logic [31:0]                      eng_wdata,
  output win_cfg_t [NUM_WIN-1:0]           cfg_q,
  output logic [NUM_WIN-1:0][DTYPE_W-1:0]  dtype_q,
  output logic                             eng_en_q,
  output logic [ECS_W-1:0]                 eng_cs_q
);
  win_cfg_t [NUM_WIN-1:0]          cfg_d;
  logic [NUM_WIN-1:0][DTYPE_W-1:0] dtype_d;
  logic                            eng_en_d;
  logic [ECS_W-1:0]                eng_cs_d;
  win_cfg_t                        wr_cfg;

  // Only the base, valid and size-code fields are stored.
  always_comb begin
    wr_cfg.base  = win_wdata[BASE_W-1:0];
    wr_cfg.valid = win_wdata[VALID_BIT];
    wr_cfg.mask  = win_wdata[MASK_LSB +: MASK_W];
  end

  always_comb begin
    cfg_d    = cfg_q;
    dtype_d  = dtype_q;
    eng_en_d = eng_wdata[ENG_EN_BIT];
    eng_cs_d = eng_wdata[ENG_CS_LSB +: ECS_W];
    for (int i = 0; i < NUM_WIN; i++) begin
      if (win_idx == IDX_W'(i)) begin
        cfg_d[i]   = wr_cfg;
        dtype_d[i] = type_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        cfg_q[i].mask  <= MASK_RST;
        cfg_q[i].valid <= (i == 0);
        cfg_q[i].base  <= '0;
        dtype_q[i]     <= '0;
      end
      eng_en_q <= 1'b0;
      eng_cs_q <= '0;
    end else begin
      if (win_we)  cfg_q   <= cfg_d;
      if (type_we) dtype_q <= dtype_d;
      if (eng_we) begin
        eng_en_q <= eng_en_d;
        eng_cs_q <= eng_cs_d;
      end
    end
  end
endmodule

// File: rtl/cswd_win_match.sv
module cswd_win_match
  import cswd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  win_cfg_t          cfg,
  input  logic              accept_256,
  output logic              hit,
  output logic              bad
);
  localparam int HI_LSB = UNIT_LSB + MASK_W;
  localparam int HI_W   = ADDR_W - HI_LSB;

  logic [HI_W-1:0]   hi_ref;
  logic [MASK_W-1:0] lo_diff;

  always_comb begin
    hi_ref  = HI_W'(cfg.base[BASE_W-1:MASK_W]);
    lo_diff = (addr[UNIT_LSB +: MASK_W] ^ cfg.base[MASK_W-1:0]) & cfg.mask;
    hit     = cfg.valid && (addr[ADDR_W-1:HI_LSB] == hi_ref) && (lo_diff == '0);
    bad     = cfg.valid && !mask_is_legal(cfg.mask, accept_256);
  end
endmodule

// File: rtl/cswd_prio_sel.sv
module cswd_prio_sel #(
  parameter int NUM_WIN = 8
) (
  input  logic [NUM_WIN-1:0] hit,
  output logic [NUM_WIN-1:0] sel,
  output logic               miss
);
  logic found;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit[i] && !found) begin
        sel[i] = 1'b1;
        found  = 1'b1;
      end
    end
    miss = !found;
  end
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import cswd_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept_256,
  input  logic               win_we,
  input  logic [IDX_W-1:0]   win_idx,
  input  logic [31:0]        win_wdata,
  input  logic               type_we,
  input  logic [1:0]         type_wdata,
  input  logic               eng_we,
  input  logic [31:0]        eng_wdata,
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_WIN-1:0] win_sel,
  output logic               win_miss,
  output logic               to_fifo,
  output logic [NUM_WIN-1:0] mask_bad
);
  logic                            rst_n_sync;
  win_cfg_t [NUM_WIN-1:0]          cfg;
  logic [NUM_WIN-1:0][DTYPE_W-1:0] dtype;
  logic                            eng_en;
  logic [ECS_W-1:0]                eng_cs;
  logic [NUM_WIN-1:0]              hit;
  logic [NUM_WIN-1:0]              route;

  cswd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cswd_cfg_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .win_we     (win_we),
    .win_idx    (win_idx),
    .win_wdata  (win_wdata),
    .type_we    (type_we),
    .type_wdata (type_wdata),
    .eng_we     (eng_we),
    .eng_wdata  (eng_wdata),
    .cfg_q      (cfg),
    .dtype_q    (dtype),
    .eng_en_q   (eng_en),
    .eng_cs_q   (eng_cs)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    cswd_win_match #(.ADDR_W(ADDR_W)) u_match (
      .addr       (addr),
      .cfg        (cfg[g]),
      .accept_256 (accept_256),
      .hit        (hit[g]),
      .bad        (mask_bad[g])
    );
    assign route[g] = eng_en && (dtype[g] == DT_NAND) && (eng_cs == ECS_W'(g));
  end

  cswd_prio_sel #(.NUM_WIN(NUM_WIN)) u_prio (
    .hit  (hit),
    .sel  (win_sel),
    .miss (win_miss)
  );

  assign to_fifo = |(win_sel & route);
endmodule

// File: rtl/cswd_checker.sv
module cswd_checker #(
  parameter int NUM_WIN = 8,
  parameter int ADDR_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               accept_256,
  input logic               win_we,
  input logic               type_we,
  input logic               eng_we,
  input logic [ADDR_W-1:0]  addr,
  input logic [NUM_WIN-1:0] win_sel,
  input logic               win_miss,
  input logic               to_fifo,
  input logic [NUM_WIN-1:0] mask_bad
);
  // R5: never more than one window selected
  p_onehot_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_sel));

  // R6: miss and select are mutually exclusive and exhaustive
  p_miss_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_miss == (win_sel == '0));

  // R9: steering requires a selected window
  p_fifo_needs_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    to_fifo |-> !win_miss);

  // R7: with no write in the last cycle and a steady address, outputs hold
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(addr) && $stable(accept_256) &&
     !$past(win_we) && !$past(type_we) && !$past(eng_we))
    |-> ($stable(win_sel) && $stable(to_fifo) && $stable(mask_bad)));

  // R8: allowing 256 MB windows never raises a new flag
  p_acc_relax_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(accept_256) && !$past(win_we))
    |-> ((mask_bad & ~$past(mask_bad)) == '0));
endmodule

bind cs_window_decoder cswd_checker #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .accept_256 (accept_256),
  .win_we     (win_we),
  .type_we    (type_we),
  .eng_we     (eng_we),
  .addr       (addr),
  .win_sel    (win_sel),
  .win_miss   (win_miss),
  .to_fifo    (to_fifo),
  .mask_bad   (mask_bad)
);

// File: tb/test_cs_window_decoder.sv
`timescale 1ns/1ps
module test_cs_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        accept_256;
  logic        win_we;
  logic [2:0]  win_idx;
  logic [31:0] win_wdata;
  logic        type_we;
  logic [1:0]  type_wdata;
  logic        eng_we;
  logic [31:0] eng_wdata;
  logic [31:0] addr;
  logic [7:0]  win_sel;
  logic        win_miss;
  logic        to_fifo;
  logic [7:0]  mask_bad;

  int n_checks = 0;
  int n_fail   = 0;

  logic [5:0] m_base [8];
  logic [3:0] m_mask [8];
  logic       m_valid[8];
  logic [1:0] m_type [8];
  logic       m_en;
  logic [2:0] m_cs;

  always #2 clk = ~clk;

  cs_window_decoder i_cs_window_decoder (
    .clk(clk), .rst_n(rst_n), .accept_256(accept_256),
    .win_we(win_we), .win_idx(win_idx), .win_wdata(win_wdata),
    .type_we(type_we), .type_wdata(type_wdata),
    .eng_we(eng_we), .eng_wdata(eng_wdata),
    .addr(addr), .win_sel(win_sel), .win_miss(win_miss),
    .to_fifo(to_fifo), .mask_bad(mask_bad)
  );

  task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s addr=%h actual=%h expected=%h", tag, what, addr, act, exp);
    end
  endtask

  // Expected outputs from the requirement text (R3, R4, R5, R8, R9)
  task automatic check_now(input string tag);
    logic [7:0] e_sel = '0;
    logic [7:0] e_bad = '0;
    logic       e_fifo = 1'b0;
    bit         got = 0;
    for (int i = 0; i < 8; i++) begin
      bit m = m_valid[i] && (addr[31:28] == {2'b00, m_base[i][5:4]}) &&
              (((addr[27:24] ^ m_base[i][3:0]) & m_mask[i]) == 4'h0);
      if (m && !got) begin
        got = 1; e_sel[i] = 1'b1;
        e_fifo = m_en && (m_type[i] == 2'd2) && (m_cs == 3'(i));
      end
      e_bad[i] = m_valid[i] && !((m_mask[i] == 4'h8) || (m_mask[i] == 4'hC) ||
                 (m_mask[i] == 4'hE) || (m_mask[i] == 4'hF) ||
                 (m_mask[i] == 4'h0 && accept_256));
    end
    cmp(tag, "win_sel",  32'(win_sel),  32'(e_sel));
    cmp(tag, "win_miss", 32'(win_miss), 32'(!got));
    cmp(tag, "to_fifo",  32'(to_fifo),  32'(e_fifo));
    cmp(tag, "mask_bad", 32'(mask_bad), 32'(e_bad));
  endtask

  task automatic check_addr(input logic [31:0] a, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    check_now(tag);
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 64; a++)
      check_addr((32'(a) << 24) | ((32'(a) * 32'h0001_3579) & 32'h00FF_FFFF), tag);
    check_addr(32'h4000_0000, tag);
    check_addr(32'hFFFF_FFFF, tag);
    check_addr(32'h3FFF_FFFF, tag);
  endtask

  task automatic wr_win(input int idx, input logic [5:0] b, input logic [3:0] m,
                        input logic v, input logic [31:0] junk);
    @(negedge clk);
    win_we    = 1'b1;
    win_idx   = 3'(idx);
    win_wdata = (junk & ~32'h0000_0F7F) | (32'(m) << 8) | (32'(v) << 6) | 32'(b);
    @(negedge clk);
    win_we = 1'b0;
    m_base[idx] = b; m_mask[idx] = m; m_valid[idx] = v;
  endtask

  task automatic wr_type(input int idx, input logic [1:0] t);
    @(negedge clk);
    type_we = 1'b1; win_idx = 3'(idx); type_wdata = t;
    @(negedge clk);
    type_we = 1'b0;
    m_type[idx] = t;
  endtask

  task automatic wr_eng(input logic en, input logic [2:0] cs, input logic [31:0] junk);
    @(negedge clk);
    eng_we    = 1'b1;
    eng_wdata = (junk & ~32'h0700_0080) | (32'(en) << 7) | (32'(cs) << 24);
    @(negedge clk);
    eng_we = 1'b0;
    m_en = en; m_cs = cs;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; accept_256 = 1'b0;
    win_we = 1'b0; win_idx = '0; win_wdata = '0;
    type_we = 1'b0; type_wdata = '0;
    eng_we = 1'b0; eng_wdata = '0; addr = 32'h0012_3456;
    for (int i = 0; i < 8; i++) begin
      m_base[i] = '0; m_mask[i] = 4'hF; m_valid[i] = (i == 0); m_type[i] = '0;
    end
    m_en = 1'b0; m_cs = '0;

    // R1: reset values
    repeat (3) @(posedge clk);
    check_addr(32'h0012_3456, "R1");
    check_addr(32'h0100_0000, "R1");
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    sweep("R1");

    // R2 (junk in ignored bits), R3 sizes, R5 overlap priority, R4 invalid
    wr_win(1, 6'h10, 4'hC, 1'b1, 32'hFFFF_F080);
    wr_win(2, 6'h08, 4'h8, 1'b1, 32'h1234_5080);
    wr_win(4, 6'h11, 4'hF, 1'b1, 32'hA5A5_A000);
    wr_win(5, 6'h30, 4'hF, 1'b0, 32'h0000_0080);
    sweep("R2_R3_R4_R5_R6");

    // R7: old config holds until the write edge, new one right after it
    check_addr(32'h3000_0000, "R7");
    @(negedge clk);
    win_we = 1'b1; win_idx = 3'd5;
    win_wdata = (32'hF << 8) | (32'h1 << 6) | 32'h30;
    #1;
    check_now("R7");
    @(posedge clk);
    #1;
    win_we = 1'b0;
    m_valid[5] = 1'b1;
    check_now("R7");

    // R8: 256 MB code, illegal code still decoding per R3
    wr_win(3, 6'h20, 4'h0, 1'b1, 32'h0);
    sweep("R8");
    @(negedge clk) accept_256 = 1'b1;
    sweep("R8");
    wr_win(6, 6'h38, 4'h5, 1'b1, 32'h0);
    sweep("R8_R3");
    @(negedge clk) accept_256 = 1'b0;
    sweep("R8");

    // R9, R10: FIFO-engine steering
    wr_type(1, 2'd2);
    sweep("R10");
    wr_eng(1'b1, 3'd1, 32'hF8FF_FF7F);
    sweep("R9_R10");
    wr_eng(1'b1, 3'd2, 32'h0);
    sweep("R9");
    wr_type(2, 2'd2);
    sweep("R9");
    wr_type(2, 2'd3);
    sweep("R9");
    wr_eng(1'b0, 3'd1, 32'hFFFF_FF7F);
    sweep("R9_R10");

    // R4: disable window 0
    wr_win(0, 6'h00, 4'hF, 1'b0, 32'h0);
    sweep("R4");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule